// File: doc/BRIEF.md
# Sample Phase Tuning Controller

This block selects the receive sampling phase of a high-speed SD/eMMC host interface. When software pulses `start`, the controller steps through all eight sampling phases, one at a time. For each phase it asks an external command/data engine to perform one tuning-block read. It records in an 8-bit circular pass bitmap whether each phase passed.

When the sweep is over, the controller searches the bitmap for the best phase. It first looks for a phase that has two passing neighbours on each side. If there is none, it looks for a phase with one passing neighbour on each side. The chosen phase is loaded into the 3-bit phase select output. If no phase qualifies, the controller reports an error and the phase select is left where the sweep began.

The sweep starts from the phase after the current one and walks upward modulo eight, so the last trial lands back on the starting phase. The window search checks one candidate per clock. `done` pulses once for each accepted `start`.

Top module: `phase_tune_ctrl`

## Requirements
- R1: After reset the controller is idle: `done`, `error` and `trialReq` are low, and `phaseSel` equals the parameter `RESET_PHASE` (default 0).
- R2: A sweep runs exactly eight trials. If the phase before the sweep is S, trial k (k = 1..8) is requested with `phaseSel` = (S + k) mod 8, so the eighth trial is at S itself.
- R3: A trial passes only if, in its `trialAck` cycle, `trialCmdErr` = 0, `trialDataErr` = 0 and `trialMatch` = 1. Every accepted `start` clears the pass bitmap, so results never carry over from an earlier sweep.
- R4: While `trialReq` is high, `trialTimeout` is all ones.
- R5: Primary choice: the lowest phase p (0..7) for which phases p-2, p-1, p, p+1 and p+2 (mod 8) all passed.
- R6: Fallback choice, used only when no phase meets R5: the lowest phase p for which phases p-1, p and p+1 (mod 8) all passed.
- R7: On success, `phaseSel` equals the chosen phase in the cycle where `done` is high, and `error` is low.
- R8: If neither R5 nor R6 finds a phase, `error` is high with `done`, and `phaseSel` equals the phase it had before the sweep.
- R9: `phaseSel` does not change from the rise of `trialReq` until `trialAck`. The trial flags are ignored in every cycle other than the acknowledge cycle.
- R10: `done` is high for exactly one cycle, and `error` is high only together with `done`. `done` follows the eighth acknowledge within 17 cycles.
- R11: A `start` pulse while a sweep is running is ignored: the sweep still runs eight trials and reaches the result of the original bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a tuning sweep |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No usable phase found; valid with `done` |
| trialReq | output | 1 | Request one tuning-block read at the current phase |
| trialAck | input | 1 | Trial finished; flags valid in this cycle |
| trialCmdErr | input | 1 | Command phase of the trial failed |
| trialDataErr | input | 1 | Data phase of the trial failed |
| trialMatch | input | 1 | Received block equals the expected pattern |
| trialTimeout | output | TIMEOUT_W | Data timeout value for the trial (all ones while requesting) |
| phaseSel | output | PHASE_W | Sampling phase select |

## Verification
The bench targets windows that wrap past phase 7 to phase 0, such as passes at phases 6, 7, 0, 1 and 2 or at 7, 0 and 1. A design that forgets to wrap the window would miss these or pick the wrong phase. Bitmaps with only a three-phase run, or with isolated passes, check the fallback search and the error path. A design that does not fall back, or that returns a partial window, would report a false error or land on the wrong phase.

The bench drives random flags outside the acknowledge cycles and makes some failures show only as a missing match. A controller that samples flags early, or counts an error trial as a pass, would then fill the wrong bitmap. A stray `start` injected in mid-sweep catches a controller that restarts or clears its bitmap. The phase carried over between sweeps catches a sweep that starts from the wrong phase or does not return to its start on failure.

// File: rtl/phase_tune_pkg.sv
`timescale 1ns/1ps
package phase_tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_SEARCH,
    ST_FINISH
  } tuneState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearMask;
    logic captureStart;
    logic advancePhase;
    logic recordTrial;
    logic clearScan;
    logic stepScan;
    logic enterFallback;
    logic loadChosen;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic atStart;
    logic windowHit;
    logic scanLast;
    logic inFallback;
  } dpStat_t;

endpackage

// File: rtl/phase_tune_dp.sv
`timescale 1ns/1ps
module phase_tune_dp
  import phase_tune_pkg::*;
#(
  parameter int PHASE_W       = 3,
  parameter int TIMEOUT_W     = 16,
  parameter int RESET_PHASE   = 0,
  parameter int WIDE_RADIUS   = 2,
  parameter int NARROW_RADIUS = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctl,
  input  logic                 trialCmdErr,
  input  logic                 trialDataErr,
  input  logic                 trialMatch,
  output dpStat_t              stat,
  output logic [PHASE_W-1:0]   phaseSel,
  output logic [PHASE_W-1:0]   startPhase,
  output logic [TIMEOUT_W-1:0] trialTimeout
);

  localparam int NUM_PH = 1 << PHASE_W;

  logic [NUM_PH-1:0]  passMask;
  logic [PHASE_W-1:0] scanIdx;
  logic               inFallback;
  logic [NUM_PH-1:0]  wideOk;
  logic [NUM_PH-1:0]  narrowOk;
  logic               trialPass;

  // true when every phase within radius of centre passed (circular)
  function automatic logic windowOk(input logic [NUM_PH-1:0] m,
                                    input int centre, input int radius);
    logic ok;
    ok = 1'b1;
    for (int k = -radius; k <= radius; k++) begin
      int pos;
      pos = (centre + k + NUM_PH) % NUM_PH;
      ok = ok & m[pos[PHASE_W-1:0]];
    end
    return ok;
  endfunction

  generate
    for (genvar g = 0; g < NUM_PH; g++) begin : gWindow
      always_comb begin
        wideOk[g]   = windowOk(passMask, g, WIDE_RADIUS);
        narrowOk[g] = windowOk(passMask, g, NARROW_RADIUS);
      end
    end
  endgenerate

  assign trialPass = !trialCmdErr && !trialDataErr && trialMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseSel     <= PHASE_W'(RESET_PHASE);
      startPhase   <= PHASE_W'(RESET_PHASE);
      passMask     <= '0;
      scanIdx      <= '0;
      inFallback   <= 1'b0;
      trialTimeout <= '0;
    end else begin
      if (ctl.clearMask)    passMask   <= '0;
      if (ctl.captureStart) startPhase <= phaseSel;
      if (ctl.advancePhase) begin
        phaseSel     <= phaseSel + 1'b1;
        trialTimeout <= '1;
      end
      if (ctl.recordTrial && trialPass) passMask[phaseSel] <= 1'b1;
      if (ctl.clearScan) begin
        scanIdx    <= '0;
        inFallback <= 1'b0;
      end
      if (ctl.stepScan)      scanIdx    <= scanIdx + 1'b1;
      if (ctl.enterFallback) inFallback <= 1'b1;
      if (ctl.loadChosen)    phaseSel   <= scanIdx;
    end
  end

  always_comb begin
    stat.atStart    = (phaseSel == startPhase);
    stat.windowHit  = inFallback ? narrowOk[scanIdx] : wideOk[scanIdx];
    stat.scanLast   = (scanIdx == PHASE_W'(NUM_PH - 1));
    stat.inFallback = inFallback;
  end

  // R3: bitmap is empty right after it is cleared
  assert_mask_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearMask |=> passMask == '0);

  // R3: a failing trial never sets a bitmap bit
  assert_fail_not_recorded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.recordTrial && (trialCmdErr || trialDataErr || !trialMatch) && !ctl.clearMask)
      |=> $stable(passMask));

endmodule

// File: rtl/phase_tune_fsm.sv
`timescale 1ns/1ps
module phase_tune_fsm
  import phase_tune_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    trialAck,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    trialReq,
  output logic    done,
  output logic    error
);

  tuneState_e state, stateNext;
  logic       failReg, failNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      failReg <= 1'b0;
    end else begin
      state   <= stateNext;
      failReg <= failNext;
    end
  end

  always_comb begin
    stateNext = state;
    failNext  = failReg;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clearMask    = 1'b1;
          ctl.captureStart = 1'b1;
          stateNext        = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        ctl.advancePhase = 1'b1;
        stateNext        = ST_WAIT;
      end
      ST_WAIT: begin
        if (trialAck) begin
          ctl.recordTrial = 1'b1;
          if (stat.atStart) begin
            ctl.clearScan = 1'b1;
            stateNext     = ST_SEARCH;
          end else begin
            stateNext = ST_LAUNCH;
          end
        end
      end
      ST_SEARCH: begin
        if (stat.windowHit) begin
          ctl.loadChosen = 1'b1;
          failNext       = 1'b0;
          stateNext      = ST_FINISH;
        end else if (stat.scanLast && stat.inFallback) begin
          failNext  = 1'b1;
          stateNext = ST_FINISH;
        end else begin
          ctl.stepScan = 1'b1;
          if (stat.scanLast) ctl.enterFallback = 1'b1;
        end
      end
      ST_FINISH: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign trialReq = (state == ST_WAIT);
  assign done     = (state == ST_FINISH);
  assign error    = done && failReg;

  // R10: done lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: error only with done
  assert_error_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R11: start while busy does not return the controller to idle
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_WAIT && !trialAck) |=> state == ST_WAIT);

endmodule

// File: rtl/phase_tune_ctrl.sv
`timescale 1ns/1ps
module phase_tune_ctrl
  import phase_tune_pkg::*;
#(
  parameter int PHASE_W     = 3,
  parameter int TIMEOUT_W   = 16,
  parameter int RESET_PHASE = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 done,
  output logic                 error,
  output logic                 trialReq,
  input  logic                 trialAck,
  input  logic                 trialCmdErr,
  input  logic                 trialDataErr,
  input  logic                 trialMatch,
  output logic [TIMEOUT_W-1:0] trialTimeout,
  output logic [PHASE_W-1:0]   phaseSel
);

  dpCtrl_t            ctl;
  dpStat_t            stat;
  logic [PHASE_W-1:0] startPhase;

  phase_tune_fsm fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .trialAck (trialAck),
    .stat     (stat),
    .ctl      (ctl),
    .trialReq (trialReq),
    .done     (done),
    .error    (error)
  );

  phase_tune_dp #(
    .PHASE_W       (PHASE_W),
    .TIMEOUT_W     (TIMEOUT_W),
    .RESET_PHASE   (RESET_PHASE),
    .WIDE_RADIUS   (2),
    .NARROW_RADIUS (1)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .trialCmdErr  (trialCmdErr),
    .trialDataErr (trialDataErr),
    .trialMatch   (trialMatch),
    .stat         (stat),
    .phaseSel     (phaseSel),
    .startPhase   (startPhase),
    .trialTimeout (trialTimeout)
  );

  // R9: phase held while a trial is outstanding
  assert_phase_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trialReq && !trialAck) |=> $stable(phaseSel));

  // R2: each new request is one phase above the previous value
  assert_phase_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trialReq) |-> phaseSel == PHASE_W'($past(phaseSel) + 1'b1));

  // R4: timeout at maximum while requesting
  assert_timeout_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    trialReq |-> &trialTimeout);

  // R8: failure leaves the sweep's start phase
  assert_fail_restores_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> phaseSel == startPhase);

endmodule

// File: tb/phase_tune_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_tune_ctrl_tb_top;

  localparam int PW = 3;
  localparam int NP = 8;
  localparam int TW = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic trialAck = 1'b0, trialCmdErr = 1'b0, trialDataErr = 1'b0, trialMatch = 1'b0;
  logic done, error, trialReq;
  logic [TW-1:0] trialTimeout;
  logic [PW-1:0] phaseSel;

  int vecCount = 0, missCount = 0, cycleCount = 0;
  int modelPhase = 0;

  always #10 clk = ~clk; // 50 MHz

  phase_tune_ctrl #(.PHASE_W(PW), .TIMEOUT_W(TW), .RESET_PHASE(0)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .error(error),
    .trialReq(trialReq), .trialAck(trialAck), .trialCmdErr(trialCmdErr),
    .trialDataErr(trialDataErr), .trialMatch(trialMatch),
    .trialTimeout(trialTimeout), .phaseSel(phaseSel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      missCount++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cycleCount, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  // expected choice from the window rules (R5 primary, R6 fallback); -1 = none
  function automatic int expectedChoice(input logic [NP-1:0] pv);
    for (int radius = 2; radius >= 1; radius--) begin
      for (int p = 0; p < NP; p++) begin
        bit all = 1'b1;
        for (int d = -radius; d <= radius; d++) begin
          if (!pv[(p + d + NP) % NP]) all = 1'b0;
        end
        if (all) return p;
      end
    end
    return -1;
  endfunction

  task automatic runSweep(input logic [NP-1:0] passVec, input bit injectStart);
    int sweepStart = modelPhase;
    int expect_ = expectedChoice(passVec);
    int trials = 0, waitLeft = -1, reqPhase = 0, ackCyc = 0, cyc = 0;
    bit doneSeen = 1'b0, injected = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!doneSeen && cyc < 2000) begin
      trialAck = 1'b0;
      start = 1'b0;
      // random flag values outside acknowledge cycles (R9)
      trialCmdErr  = 1'($urandom);
      trialDataErr = 1'($urandom);
      trialMatch   = 1'($urandom);
      if (done) begin
        doneSeen = 1'b1;
        check(trials == NP, "R2", "trial count", trials, NP);
        check(cyc - ackCyc <= 17, "R10", "done latency", cyc - ackCyc, 17);
        if (expect_ >= 0) begin
          check(error == 1'b0, "R7", "error on success", int'(error), 0);
          check(int'(phaseSel) == expect_, "R5/R6 R7", "chosen phase", int'(phaseSel), expect_);
        end else begin
          check(error == 1'b1, "R8", "error on no window", int'(error), 1);
          check(int'(phaseSel) == sweepStart, "R8", "phase restored", int'(phaseSel), sweepStart);
        end
      end else if (trialReq) begin
        if (waitLeft < 0) begin
          check(int'(phaseSel) == (sweepStart + trials + 1) % NP, "R2", "trial phase",
                int'(phaseSel), (sweepStart + trials + 1) % NP);
          check(&trialTimeout, "R4", "timeout all ones", int'(trialTimeout), (1 << TW) - 1);
          reqPhase = int'(phaseSel);
          waitLeft = int'($urandom % 4);
        end else begin
          check(int'(phaseSel) == reqPhase, "R9", "phase held", int'(phaseSel), reqPhase);
        end
        if (waitLeft == 0) begin
          trialAck = 1'b1;
          if (passVec[phaseSel]) begin
            trialCmdErr = 1'b0; trialDataErr = 1'b0; trialMatch = 1'b1;
          end else begin
            // R3: any one failure kind makes the trial fail
            case ($urandom % 3)
              0: begin trialCmdErr = 1'b1; trialDataErr = 1'b0; trialMatch = 1'b1; end
              1: begin trialCmdErr = 1'b0; trialDataErr = 1'b1; trialMatch = 1'b1; end
              default: begin trialCmdErr = 1'b0; trialDataErr = 1'b0; trialMatch = 1'b0; end
            endcase
          end
          trials++;
          waitLeft = -1;
          ackCyc = cyc;
        end else begin
          waitLeft--;
        end
      end
      // R11: stray start in mid-sweep
      if (injectStart && trials == 3 && !injected) begin
        start = 1'b1;
        injected = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    check(doneSeen, "R10", "done seen", int'(doneSeen), 1);
    trialAck = 1'b0; start = 1'b0;
    check(done == 1'b0, "R10", "done one cycle", int'(done), 0);
    check(error == 1'b0, "R10", "error without done", int'(error), 0);
    if (expect_ >= 0) modelPhase = expect_;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(error == 1'b0, "R1", "error in reset", int'(error), 0);
    check(trialReq == 1'b0, "R1", "trialReq in reset", int'(trialReq), 0);
    check(phaseSel == '0, "R1", "phaseSel in reset", int'(phaseSel), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(trialReq == 1'b0, "R1", "idle after reset", int'(trialReq), 0);

    runSweep(8'hFF, 1'b0); // R5 all pass -> 0
    runSweep(8'h00, 1'b0); // R8 nothing passes
    runSweep(8'h3E, 1'b0); // R5 phases 1..5 -> 3
    runSweep(8'h38, 1'b0); // R6 phases 3..5 -> 4
    runSweep(8'hC7, 1'b1); // R5 wrap 6,7,0,1,2 -> 0, with R11 stray start
    runSweep(8'h83, 1'b0); // R6 wrap 7,0,1 -> 0
    runSweep(8'h55, 1'b0); // R8 isolated passes
    runSweep(8'hF1, 1'b0); // R5 4..0 -> 6
    runSweep(8'h0E, 1'b1); // R6 1..3 -> 2, R3 bitmap from earlier sweep not reused
    runSweep(8'h77, 1'b0); // R6 two three-phase runs -> 1

    for (int n = 0; n < 40; n++) begin
      logic [NP-1:0] pv;
      pv = NP'($urandom) | NP'($urandom);
      if (n % 5 == 0) pv = NP'($urandom);
      runSweep(pv, (n % 4) == 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule